// File: doc/BRIEF.md
# Opcode Fetch Bus Sequencer

This block produces the bus-control waveform for the instruction-fetch machine cycle of an 8-bit processor. A fetch takes four clock states, T1 through T4. During the first half of the cycle the program counter is on the address bus and the memory-request and read strobes are low, so memory can put the opcode on the data bus. The opcode is captured on the rising edge that opens T3. The second half of the cycle is a refresh slot for dynamic memory. In that slot the low address bits carry a 7-bit refresh row, the refresh strobe is low and read stays high.

The strobes move on both clock edges. State advances on the rising edge. A second register takes a copy of the state on the falling edge, and each strobe is decoded from the two registers together. A caller raises `fetch_req` with the program counter on `pc_in`. A request seen in idle, or at the end of T4, starts a fetch on the next rising edge. Back-to-back fetches therefore run with no idle state between them.

Top module: `fetch_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the sequencer returns to idle. All four strobes are then high, `addr_out` is 0 and `opcode_vld` is 0, and the refresh row counter is cleared, so the next fetch refreshes row 0.
- R2: When `fetch_req` is high at a rising edge in idle, T1 starts on that edge. The value of `pc_in` at that edge is held on `addr_out` through T1 and T2, whatever `pc_in` does afterwards.
- R3: `mreq_n` and `rd_n` are high in the first half of T1. Both go low on the falling edge inside T1 and stay low through T2. Both return high on the rising edge that starts T3.
- R4: `opcode` takes the value of `data_in` at the rising edge that starts T3 and holds it until the next capture. `opcode_vld` is high for exactly the one clock of T3.
- R5: `rfsh_n` is low for all of T3 and T4 and high in every other state. In T3 and T4, `addr_out` equals the refresh row in bits 6:0, and all bits above bit 6 are zero.
- R6: `rd_n` is never low while `rfsh_n` is low.
- R7: In the refresh slot, `mreq_n` is high in the first half of T3. It is low from the falling edge inside T3 until the falling edge inside T4, and high again for the second half of T4.
- R8: The refresh row goes up by one at the end of each completed fetch and wraps from 127 to 0.
- R9: `m1_n` is low in T1 and T2 only and high in T3, T4 and idle.
- R10: `fetch_req` is ignored in T1, T2 and T3. If `fetch_req` is high at the rising edge ending T4, T1 of the next fetch starts on that edge. Otherwise the sequencer goes idle, where `addr_out` is 0 and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state moves on the rising edge, strobe phases on the falling edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_req | input | 1 | Request to start a fetch cycle |
| pc_in | input | 16 | Program counter, captured when a fetch starts |
| data_in | input | 8 | Data bus from memory |
| addr_out | output | 16 | Address bus: program counter in T1/T2, refresh row in T3/T4, 0 when idle |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| m1_n | output | 1 | Fetch-cycle indicator, active low |
| opcode | output | 8 | Captured opcode byte |
| opcode_vld | output | 1 | One-clock pulse after the opcode is captured |

## Verification
A wrong rising-edge state shows up within half a clock: the bench samples both halves of every state, so any strobe decoded from that state is wrong at the next sample. A stale falling-edge phase copy shows only in the half-cycle windows of T1 and T3, where `mreq_n` and `rd_n` must change state. A refresh counter that skips or fails to wrap stays hidden until the next T3, where `addr_out` exposes it. For that reason the bench runs more than 128 fetches and compares the refresh row every time.

// File: rtl/fcs_pkg.sv
// Package: shared state encoding for the fetch bus sequencer.
// Assumes: one fetch cycle is exactly four clock states with no wait states.
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } fcs_state_e;

endpackage

// File: rtl/fcs_phase_fsm.sv
// Module: fcs_phase_fsm
// Steps through the fetch states on the rising edge. It also keeps a copy of
// the state taken on the falling edge, so later logic can tell the first half
// of a state from the second half.
// Assumes: fetch_req is synchronous to clk and is only looked at in idle and T4.
module fcs_phase_fsm
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_req,
    output fcs_state_e state,
    output fcs_state_e half_state,
    output logic       launch,
    output logic       cyc_end
);

    fcs_state_e state_nx;

    // A new fetch may begin only from idle or from the last state of a fetch.
    assign launch  = fetch_req && (state == ST_IDLE || state == ST_T4);
    assign cyc_end = (state == ST_T4);

    // Next-state selection for the four-state fetch.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = launch ? ST_T1 : ST_IDLE;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3:   state_nx = ST_T4;
            ST_T4:   state_nx = launch ? ST_T1 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Rising-edge state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Falling-edge copy of the state; marks the second half of each state.
    always_ff @(negedge clk) begin
        if (!rst_n) half_state <= ST_IDLE;
        else        half_state <= state;
    end

    // R10: with no request at the end of T4, the sequencer goes idle.
    a_r10_idle_after_t4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4 && !fetch_req) |=> (state == ST_IDLE));

    // R10: a request in T1..T3 does not change the fixed order of states.
    a_r10_req_ignored_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T2) |=> (state == ST_T3));

endmodule

// File: rtl/fcs_refresh_ctr.sv
// Module: fcs_refresh_ctr
// Row counter for dynamic-memory refresh. It goes up by one at the end of
// each fetch and wraps at its width.
// Assumes: adv is high for exactly one clock per completed fetch.
module fcs_refresh_ctr #(
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [RFSH_W-1:0] row
);

    // Row register; natural binary wrap from all-ones to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + 1'b1;
    end

endmodule

// File: rtl/fcs_bus_drive.sv
// Module: fcs_bus_drive
// Builds the address bus and the four control strobes from the rising-edge
// state and the falling-edge state copy. It also captures the opcode.
// Assumes: half_state lags state by half a clock; launch is high on the
// rising edge that enters T1.
module fcs_bus_drive
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fcs_state_e        state,
    input  fcs_state_e        half_state,
    input  logic              launch,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [RFSH_W-1:0] row,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              rfsh_n,
    output logic              m1_n,
    output logic [DATA_W-1:0] opcode,
    output logic              opcode_vld
);

    localparam int HI_W = ADDR_W - RFSH_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] rfsh_addr;
    logic              fetch_phase;
    logic              refresh_phase;
    logic              t1_late;
    logic              t3_late;
    logic              t4_early;

    // Pad the refresh row up to the address width; zero-extend when wider.
    generate
        if (HI_W > 0) begin : g_pad
            assign rfsh_addr = {{HI_W{1'b0}}, row};
        end else begin : g_nopad
            assign rfsh_addr = row[ADDR_W-1:0];
        end
    endgenerate

    // Hold the program counter for the address half of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (launch) pc_q <= pc_in;
    end

    // Capture the opcode on the edge that leaves T2; flag it for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode     <= '0;
            opcode_vld <= 1'b0;
        end else begin
            opcode_vld <= (state == ST_T2);
            if (state == ST_T2) opcode <= data_in;
        end
    end

    // Decode which half of the cycle, and which half-state, is current.
    always_comb begin
        fetch_phase   = (state == ST_T1) || (state == ST_T2);
        refresh_phase = (state == ST_T3) || (state == ST_T4);
        t1_late       = (state == ST_T1) && (half_state == ST_T1);
        t3_late       = (state == ST_T3) && (half_state == ST_T3);
        t4_early      = (state == ST_T4) && (half_state == ST_T3);
    end

    // Drive the strobes and the address bus.
    always_comb begin
        m1_n     = !fetch_phase;
        rfsh_n   = !refresh_phase;
        rd_n     = !(t1_late || state == ST_T2);
        mreq_n   = !(t1_late || state == ST_T2 || t3_late || t4_early);
        if (fetch_phase)        addr_out = pc_q;
        else if (refresh_phase) addr_out = rfsh_addr;
        else                    addr_out = '0;
    end

    // R6: read is never active while refresh is active (both clock edges).
    a_r6_no_read_in_refresh_p: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> rd_n);
    a_r6_no_read_in_refresh_n: assert property (@(negedge clk) disable iff (!rst_n)
        !rfsh_n |-> rd_n);

    // R3: by the end of T1, memory request and read are both active.
    a_r3_strobes_low_late_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1) |-> (!mreq_n && !rd_n));

    // R3: in the first half of T3, both strobes are already released.
    a_r3_released_early_t3: assert property (@(negedge clk) disable iff (!rst_n)
        (state == ST_T3) |-> (mreq_n && rd_n));

    // R7: by the end of T3, memory request is active again during refresh.
    a_r7_refresh_mreq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T3) |-> (!mreq_n && !rfsh_n));

    // R4: the valid flag is a single-clock pulse.
    a_r4_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_vld |=> !opcode_vld);

endmodule

// File: rtl/fetch_cycle_seq.sv
// Module: fetch_cycle_seq (top)
// Bus sequencer for the four-state opcode fetch. T1 and T2 carry the program
// counter, with memory request and read active. T3 and T4 are a refresh slot
// that drives the row counter onto the low address bits.
// Assumes: a single clock domain; strobes are decoded from registers that
// change on opposite clock edges.
module fetch_cycle_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              rfsh_n,
    output logic              m1_n,
    output logic [DATA_W-1:0] opcode,
    output logic              opcode_vld
);

    fcs_state_e        state;
    fcs_state_e        half_state;
    logic              launch;
    logic              cyc_end;
    logic [RFSH_W-1:0] row;

    fcs_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .state      (state),
        .half_state (half_state),
        .launch     (launch),
        .cyc_end    (cyc_end)
    );

    fcs_refresh_ctr #(.RFSH_W(RFSH_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cyc_end),
        .row   (row)
    );

    fcs_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RFSH_W (RFSH_W)
    ) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .half_state (half_state),
        .launch     (launch),
        .pc_in      (pc_in),
        .data_in    (data_in),
        .row        (row),
        .addr_out   (addr_out),
        .mreq_n     (mreq_n),
        .rd_n       (rd_n),
        .rfsh_n     (rfsh_n),
        .m1_n       (m1_n),
        .opcode     (opcode),
        .opcode_vld (opcode_vld)
    );

    // R8: each completed fetch moves the refresh row on by one, with wrap.
    a_r8_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4) |=> (row == $past(row) + 1'b1));

    // R9: the fetch indicator is never active together with refresh.
    a_r9_m1_not_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        !(!m1_n && !rfsh_n));

endmodule

// File: tb/fetch_cycle_seq_bench.sv
`timescale 1ns/1ps
module fetch_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req;
    logic [15:0] pc_in;
    logic [7:0]  data_in;
    logic [15:0] addr_out;
    logic        mreq_n, rd_n, rfsh_n, m1_n;
    logic [7:0]  opcode;
    logic        opcode_vld;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic [6:0] exp_row;

    always #2.5 clk = ~clk;

    fetch_cycle_seq u_fetch_cycle_seq (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .pc_in(pc_in),
        .data_in(data_in), .addr_out(addr_out), .mreq_n(mreq_n), .rd_n(rd_n),
        .rfsh_n(rfsh_n), .m1_n(m1_n), .opcode(opcode), .opcode_vld(opcode_vld)
    );

    function automatic logic [15:0] refresh_addr(input logic [6:0] r);
        return {9'd0, r};
    endfunction

    function automatic logic [3:0] pack_strobes(input logic m, input logic r,
                                                input logic f, input logic i);
        return {m, r, f, i};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", rq, $time, act, exp);
        end
    endtask

    // Strobe vector order: {mreq_n, rd_n, rfsh_n, m1_n}
    task automatic chk_strobes(input string rq, input logic [3:0] exp);
        chk(rq, {28'd0, pack_strobes(mreq_n, rd_n, rfsh_n, m1_n)}, {28'd0, exp});
    endtask

    // Runs one fetch. Entry: a request and pc are already set up, sampled at
    // the next rising edge. Exit: the second half of T4, fetch_req = chain.
    task automatic do_fetch(input logic [15:0] pc, input logic [7:0] op, input bit chain);
        @(posedge clk); #1;                                  // T1 first half
        chk_strobes("R3/R9 T1 early", 4'b1110);
        chk("R2 addr T1", {16'd0, addr_out}, {16'd0, pc});
        fetch_req = 1'($urandom);                            // R10: ignored here
        pc_in     = 16'($urandom);                           // R2: must not leak
        data_in   = 8'($urandom);
        @(negedge clk); #1;                                  // T1 second half
        chk_strobes("R3 T1 late", 4'b0010);
        @(posedge clk); #1;                                  // T2 first half
        chk_strobes("R3 T2", 4'b0010);
        chk("R2 addr T2", {16'd0, addr_out}, {16'd0, pc});
        fetch_req = 1'($urandom);
        @(negedge clk); #1;                                  // T2 second half
        chk_strobes("R3 T2 late", 4'b0010);
        data_in = op;
        @(posedge clk); #1;                                  // T3 first half
        chk_strobes("R3/R5/R7 T3 early", 4'b1101);
        chk("R5/R8 refresh addr T3", {16'd0, addr_out}, {16'd0, refresh_addr(exp_row)});
        chk("R4 opcode", {24'd0, opcode}, {24'd0, op});
        chk("R4 valid T3", {31'd0, opcode_vld}, 32'd1);
        data_in   = 8'($urandom);
        fetch_req = 1'($urandom);
        @(negedge clk); #1;                                  // T3 second half
        chk_strobes("R6/R7 T3 late", 4'b0101);
        fetch_req = chain;
        @(posedge clk); #1;                                  // T4 first half
        chk_strobes("R6/R7 T4 early", 4'b0101);
        chk("R5 refresh addr T4", {16'd0, addr_out}, {16'd0, refresh_addr(exp_row)});
        chk("R4 valid T4", {31'd0, opcode_vld}, 32'd0);
        chk("R4 opcode held", {24'd0, opcode}, {24'd0, op});
        @(negedge clk); #1;                                  // T4 second half
        chk_strobes("R7 T4 late", 4'b1101);
        exp_row = exp_row + 7'd1;                            // R8: wrap at 127
    endtask

    task automatic check_idle(input string rq);
        @(posedge clk); #1;
        chk_strobes(rq, 4'b1111);
        chk({rq, " addr"}, {16'd0, addr_out}, 32'd0);
        chk({rq, " valid"}, {31'd0, opcode_vld}, 32'd0);
    endtask

    initial begin
        logic [15:0] pc;
        logic [7:0]  op;
        bit          chain;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fetch_req = 1'b0; pc_in = '0; data_in = '0; exp_row = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_strobes("R1 reset strobes", 4'b1111);
        chk("R1 reset addr", {16'd0, addr_out}, 32'd0);
        chk("R1 reset valid", {31'd0, opcode_vld}, 32'd0);
        @(negedge clk); #1;
        chk_strobes("R1 reset strobes late", 4'b1111);
        rst_n = 1'b1;
        check_idle("R10 idle no request");

        // Directed: single fetches with boundary pc and opcode values.
        pc_in = 16'hFFFF; fetch_req = 1'b1;
        do_fetch(16'hFFFF, 8'h00, 1'b0);
        check_idle("R10 idle after fetch");
        pc_in = 16'h0000; fetch_req = 1'b1;
        do_fetch(16'h0000, 8'hFF, 1'b1);                     // back-to-back follows
        pc_in = 16'h8001; fetch_req = 1'b1;
        do_fetch(16'h8001, 8'hA5, 1'b0);
        check_idle("R10 idle after chain");

        // Reset in the middle of a fetch clears state and refresh row (R1).
        pc_in = 16'h1234; fetch_req = 1'b1;
        @(posedge clk); #1;
        fetch_req = 1'b0;
        @(posedge clk); #1;
        chk_strobes("R1 pre-reset T2", 4'b0010);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk_strobes("R1 reset mid-fetch", 4'b1111);
        chk("R1 reset mid-fetch addr", {16'd0, addr_out}, 32'd0);
        @(negedge clk); #1;
        chk_strobes("R1 reset mid-fetch late", 4'b1111);
        rst_n = 1'b1;
        exp_row = '0;
        pc_in = 16'h4321; fetch_req = 1'b1;
        do_fetch(16'h4321, 8'h3C, 1'b0);                     // R1: row 0 expected

        // Random fetches with random gaps; more than 128 to cover the wrap (R8).
        for (int i = 0; i < 300; i++) begin
            pc    = 16'($urandom);
            op    = 8'($urandom);
            chain = 1'($urandom);
            if (fetch_req == 1'b0) begin
                @(posedge clk); #1;
                chk_strobes("R10 idle gap", 4'b1111);
                for (int g = 0; g < int'($urandom % 3); g++) @(posedge clk);
                #1;
            end
            pc_in = pc; fetch_req = 1'b1;
            do_fetch(pc, op, chain);
        end
        fetch_req = 1'b0;
        check_idle("R10 final idle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule